// File: doc/BRIEF.md
# Timer Event Status Flag Register

This block holds the sticky event flags of a multi-channel advanced timer. The counter, the capture datapath, the slave controller and the break logic sit outside it. Each of them delivers its events as single-cycle pulses or levels. The block latches each event into its own flag bit. The flags stay set until software clears them by writing a 0 to the bit's position in a single 16-bit register on a simple register bus. Writing a 1 to a bit leaves that flag untouched.

Two flags carry more logic than a plain latch. First, each channel has an overcapture flag. It is raised when a capture arrives in input-capture mode while that channel's capture/compare flag is still pending, which means software has missed a captured value. Second, the break flag follows the break input as a level: a clear attempt has no effect while the break input stays active.

The trigger flag comes from either a trigger edge or, in gated mode, the counter starting or stopping. An interrupt request is formed as the OR of the flags masked by an external enable vector, and it is registered for one cycle.

Top module: `tmr_evt_status`

## Requirements
- R1: After reset the register reads 0x0000 and `irq_o` is 0.
- R2: Bit positions: update flag bit 0; channel c capture/compare flag bit 1+c; COM flag bit 5; trigger flag bit 6; break flag bit 7; channel c overcapture flag bit 9+c. An event seen at a rising clock edge shows in the register from that edge on.
- R3: A write with `bus_sel`=1, `bus_wr`=1 and `bus_addr`=0x10 clears every implemented flag whose data bit is 0 and keeps every flag whose data bit is 1. Writes to any other offset change no flag.
- R4: When a hardware event and a software clear hit the same flag in the same cycle, the flag ends set.
- R5: The capture/compare flag of channel c is set by `ev_cc[c]`, or by `cap_evt[c]` while `ic_mode[c]`=1. A `cap_evt[c]` with `ic_mode[c]`=0 sets nothing.
- R6: The overcapture flag of channel c is set only by `cap_evt[c]` with `ic_mode[c]`=1 while the channel's capture/compare flag was already set before that edge. A capture onto a clear flag sets only the capture/compare flag.
- R7: The break flag is set in every cycle in which `brk_act`=1. A clear write has no effect while `brk_act`=1, and the flag stays set after `brk_act` falls until it is cleared.
- R8: With `slave_en`=1 and `gated_mode`=0, `trig_edge` sets the trigger flag. With `slave_en`=1 and `gated_mode`=1, a change of `cnt_run` sets it and `trig_edge` is ignored. With `slave_en`=0 nothing sets it.
- R9: Bits 8 and 15:13 always read 0, and no write sets them. Reads at any other offset, or with `bus_sel`=0, return 0.
- R10: `irq_o` equals, one cycle later, the OR over all bits of the flags ANDed with `irq_en`.
- R11: `ev_upd` sets the update flag and `ev_com` sets the COM flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe (1 = write, 0 = read) |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 16 | Write data; a 0 bit clears that flag |
| bus_rdata | output | 16 | Read data, combinational |
| ev_upd | input | 1 | Update event pulse |
| ev_cc | input | 4 | Per-channel compare/capture event pulses |
| cap_evt | input | 4 | Per-channel capture strobes |
| ic_mode | input | 4 | Per-channel input-capture mode indication |
| ev_com | input | 1 | COM (control bits reloaded) event pulse |
| slave_en | input | 1 | Slave controller enabled |
| gated_mode | input | 1 | Slave controller in gated mode |
| trig_edge | input | 1 | Active trigger edge pulse |
| cnt_run | input | 1 | Counter running level |
| brk_act | input | 1 | Break input active level |
| irq_en | input | 16 | Interrupt enable mask, bit-aligned to the flags |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions check several rules on every cycle:
- an update pulse and an active break level leave their flags set on the next cycle;
- a pending update flag survives every cycle without a matching clear write;
- reserved bits stay zero;
- each overcapture flag rises only after a mode-qualified capture onto a pending capture/compare flag;
- the interrupt output tracks the masked OR with one cycle of delay.

Some behaviour only the bench scenarios can show. These are the full write-zero and write-one sweeps, the ignoring of writes to a wrong offset, the set-versus-clear collision, and the break clear that is refused while the break is active and then accepted. The same holds for the gated and non-gated trigger sources and the exhaustive channel-by-mode-by-pending capture table.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
   localparam int unsigned SR_W   = 16;
   localparam int unsigned UPD_B  = 0;
   localparam int unsigned CC_B0  = 1;
   localparam int unsigned COM_B  = 5;
   localparam int unsigned TRG_B  = 6;
   localparam int unsigned BRK_B  = 7;
   localparam int unsigned OVC_B0 = 9;
   localparam int unsigned MAX_CH = 4;

   // Mask of implemented flag bits for a given channel count
   function automatic logic [SR_W-1:0] impl_mask(input int unsigned nch);
      logic [SR_W-1:0] m;
      m = '0;
      m[UPD_B] = 1'b1;
      m[COM_B] = 1'b1;
      m[TRG_B] = 1'b1;
      m[BRK_B] = 1'b1;
      for (int unsigned c = 0; c < MAX_CH; c++) begin
         if (c < nch) begin
            m[CC_B0 + c]  = 1'b1;
            m[OVC_B0 + c] = 1'b1;
         end
      end
      return m;
   endfunction
endpackage

// File: rtl/tmr_flag_cell.sv
// Bank of sticky flags: a set in the same cycle as a clear wins.
module tmr_flag_cell #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("tmr_flag_cell: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= (q_o & ~clr_i) | set_i;
   end
endmodule

// File: rtl/tmr_cap_chan.sv
// Per-channel capture/compare flag set and overcapture detection.
module tmr_cap_chan #(
   parameter int unsigned NCH = 4
) (
   input  logic [NCH-1:0] ev_cc,
   input  logic [NCH-1:0] cap_evt,
   input  logic [NCH-1:0] ic_mode,
   input  logic [NCH-1:0] ccif_q,
   output logic [NCH-1:0] ccif_set,
   output logic [NCH-1:0] ovc_set
);
   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic cap_ok;
         // a capture counts only when the channel is in input-capture mode
         assign cap_ok      = cap_evt[c] & ic_mode[c];
         assign ccif_set[c] = ev_cc[c] | cap_ok;
         // the pending flag is sampled before this cycle's update
         assign ovc_set[c]  = cap_ok & ccif_q[c];
      end
   endgenerate
endmodule

// File: rtl/tmr_trig_src.sv
// Trigger flag source: edge pulses, or start/stop of the counter when gated.
module tmr_trig_src (
   input  logic clk,
   input  logic rst_n,
   input  logic slave_en,
   input  logic gated_mode,
   input  logic trig_edge,
   input  logic cnt_run,
   output logic trg_set
);
   logic run_q;
   logic run_chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= cnt_run;
   end

   assign run_chg = cnt_run ^ run_q;
   assign trg_set = slave_en & (gated_mode ? run_chg : trig_edge);
endmodule

// File: rtl/tmr_irq_out.sv
// Registered interrupt request from masked flags.
module tmr_irq_out #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] flags,
   input  logic [W-1:0] en,
   output logic         irq_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(flags & en);
   end
endmodule

// File: rtl/tmr_evt_status.sv
module tmr_evt_status
   import tmr_evt_pkg::*;
#(
   parameter int unsigned    NCH     = 4,
   parameter int unsigned    AW      = 8,
   parameter logic [AW-1:0]  REG_OFS = 'h10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_sel,
   input  logic            bus_wr,
   input  logic [AW-1:0]   bus_addr,
   input  logic [SR_W-1:0] bus_wdata,
   output logic [SR_W-1:0] bus_rdata,
   input  logic            ev_upd,
   input  logic [NCH-1:0]  ev_cc,
   input  logic [NCH-1:0]  cap_evt,
   input  logic [NCH-1:0]  ic_mode,
   input  logic            ev_com,
   input  logic            slave_en,
   input  logic            gated_mode,
   input  logic            trig_edge,
   input  logic            cnt_run,
   input  logic            brk_act,
   input  logic [SR_W-1:0] irq_en,
   output logic            irq_o
);
   localparam logic [SR_W-1:0] IMPL = impl_mask(NCH);

   generate
      if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
         $error("tmr_evt_status: NCH must be within 1..4");
      end
      if (AW < 5) begin : g_bad_aw
         $error("tmr_evt_status: AW too narrow for the register offset");
      end
   endgenerate

   logic [SR_W-1:0] set_v;
   logic [SR_W-1:0] clr_v;
   logic [SR_W-1:0] flag_q;
   logic [NCH-1:0]  ccif_set;
   logic [NCH-1:0]  ovc_set;
   logic            trg_set;
   logic            hit;
   logic            wr_hit;

   assign hit    = bus_sel && (bus_addr == REG_OFS);
   assign wr_hit = hit && bus_wr;

   tmr_cap_chan #(.NCH(NCH)) u_cap (
      .ev_cc    (ev_cc),
      .cap_evt  (cap_evt),
      .ic_mode  (ic_mode),
      .ccif_q   (flag_q[CC_B0 +: NCH]),
      .ccif_set (ccif_set),
      .ovc_set  (ovc_set)
   );

   tmr_trig_src u_trg (
      .clk        (clk),
      .rst_n      (rst_n),
      .slave_en   (slave_en),
      .gated_mode (gated_mode),
      .trig_edge  (trig_edge),
      .cnt_run    (cnt_run),
      .trg_set    (trg_set)
   );

   always_comb begin
      set_v        = '0;
      set_v[UPD_B] = ev_upd;
      set_v[COM_B] = ev_com;
      set_v[TRG_B] = trg_set;
      set_v[BRK_B] = brk_act;
      for (int unsigned c = 0; c < NCH; c++) begin
         set_v[CC_B0 + c]  = ccif_set[c];
         set_v[OVC_B0 + c] = ovc_set[c];
      end
   end

   always_comb begin
      clr_v        = wr_hit ? (~bus_wdata & IMPL) : '0;
      // break flag refuses a clear while the break input is active
      clr_v[BRK_B] = clr_v[BRK_B] & ~brk_act;
   end

   tmr_flag_cell #(.W(SR_W)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v & IMPL),
      .clr_i (clr_v),
      .q_o   (flag_q)
   );

   assign bus_rdata = hit ? (flag_q & IMPL) : '0;

   tmr_irq_out #(.W(SR_W)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .flags (flag_q),
      .en    (irq_en),
      .irq_q (irq_o)
   );
endmodule

// File: rtl/tmr_evt_status_chk.sv
module tmr_evt_status_chk #(
   parameter int unsigned   NCH     = 4,
   parameter int unsigned   AW      = 8,
   parameter logic [AW-1:0] REG_OFS = 'h10
) (
   input logic           clk,
   input logic           rst_n,
   input logic           bus_sel,
   input logic           bus_wr,
   input logic [AW-1:0]  bus_addr,
   input logic [15:0]    bus_wdata,
   input logic           ev_upd,
   input logic [NCH-1:0] cap_evt,
   input logic [NCH-1:0] ic_mode,
   input logic           brk_act,
   input logic [15:0]    irq_en,
   input logic [15:0]    flag_q,
   input logic           irq_o
);
   logic clr_upd;
   assign clr_upd = bus_sel && bus_wr && (bus_addr == REG_OFS) && !bus_wdata[0];

   p_upd_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ev_upd |=> flag_q[0]);

   p_upd_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[0] && !clr_upd) |=> flag_q[0]);

   p_brk_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      brk_act |=> flag_q[7]);

   p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[15:13] == 3'b000) && !flag_q[8]);

   p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o == $past(|(flag_q & irq_en))));

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ovc
         p_ovc_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[9+c]) |-> $past(cap_evt[c] && ic_mode[c] && flag_q[1+c]));
      end
   endgenerate
endmodule

bind tmr_evt_status tmr_evt_status_chk #(.NCH(NCH), .AW(AW), .REG_OFS(REG_OFS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .ev_upd    (ev_upd),
   .cap_evt   (cap_evt),
   .ic_mode   (ic_mode),
   .brk_act   (brk_act),
   .irq_en    (irq_en),
   .flag_q    (flag_q),
   .irq_o     (irq_o)
);

// File: tb/tb_tmr_evt_status.sv
module tb_tmr_evt_status;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h10;
   logic [15:0] bus_wdata = 16'hFFFF;
   logic [15:0] bus_rdata;
   logic        ev_upd = 1'b0, ev_com = 1'b0;
   logic [3:0]  ev_cc = '0, cap_evt = '0, ic_mode = '0;
   logic        slave_en = 1'b0, gated_mode = 1'b0, trig_edge = 1'b0, cnt_run = 1'b0;
   logic        brk_act = 1'b0;
   logic [15:0] irq_en = '0;
   logic        irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tmr_evt_status dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ev_upd(ev_upd), .ev_cc(ev_cc), .cap_evt(cap_evt), .ic_mode(ic_mode),
      .ev_com(ev_com), .slave_en(slave_en), .gated_mode(gated_mode),
      .trig_edge(trig_edge), .cnt_run(cnt_run), .brk_act(brk_act),
      .irq_en(irq_en), .irq_o(irq_o)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd_chk(input logic [15:0] exp, input string req);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h10;
      #1;
      chk(bus_rdata, exp, req);
      bus_sel = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 16'hFFFF; bus_addr = 8'h10;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      rd_chk(16'h0000, "R1 reset value");
      chk({15'd0, irq_o}, 16'h0000, "R1 irq after reset");

      // R11 / R2 update and COM bits
      ev_upd = 1'b1; tick(); ev_upd = 1'b0;
      rd_chk(16'h0001, "R11 update flag bit0 (R2)");
      ev_com = 1'b1; tick(); ev_com = 1'b0;
      rd_chk(16'h0021, "R11 COM flag bit5 (R2)");

      // R3 write semantics
      wr(8'h10, 16'hFFFF);
      rd_chk(16'h0021, "R3 write ones keeps flags");
      wr(8'h14, 16'h0000);
      rd_chk(16'h0021, "R3 wrong offset no effect");
      wr(8'h10, 16'hFFDF);
      rd_chk(16'h0001, "R3 clear only COM");
      wr(8'h10, 16'h0000);
      rd_chk(16'h0000, "R3 clear all");

      // R9 reserved bits and read gating
      ev_upd = 1'b1; ev_com = 1'b1; ev_cc = 4'hF; tick();
      ev_upd = 1'b0; ev_com = 1'b0; ev_cc = 4'h0;
      cap_evt = 4'hF; ic_mode = 4'hF; brk_act = 1'b1; tick();
      cap_evt = 4'h0; ic_mode = 4'h0; brk_act = 1'b0;
      wr(8'h10, 16'hFFFF);
      rd_chk(16'h1EBF, "R9 reserved read zero with all flags set");
      bus_sel = 1'b0; #1;
      chk(bus_rdata, 16'h0000, "R9 read without select is zero");
      bus_sel = 1'b1; bus_addr = 8'h11; #1;
      chk(bus_rdata, 16'h0000, "R9 read at other offset is zero");
      bus_sel = 1'b0; bus_addr = 8'h10;

      // R10 irq sweep over single-bit enables, flags = 0x1EBF
      tick();
      for (int i = 0; i < 16; i++) begin
         irq_en = 16'h0001 << i;
         tick();
         chk({15'd0, irq_o}, {15'd0, ((16'h1EBF >> i) & 16'h1) != 0}, "R10 masked irq");
      end
      irq_en = 16'hFFFF;
      wr(8'h10, 16'h0000);
      chk({15'd0, irq_o}, 16'h0001, "R10 irq still high one cycle after clear");
      tick();
      chk({15'd0, irq_o}, 16'h0000, "R10 irq low after clear");
      irq_en = '0;

      // R5 / R6 exhaustive channel x mode x pending sweep
      for (int ch = 0; ch < 4; ch++) begin
         for (int ic = 0; ic < 2; ic++) begin
            for (int pre = 0; pre < 2; pre++) begin
               logic [15:0] exp;
               wr(8'h10, 16'h0000);
               if (pre != 0) begin
                  ev_cc[ch] = 1'b1; tick(); ev_cc = '0;
               end
               cap_evt[ch] = 1'b1; ic_mode[ch] = (ic != 0); tick();
               cap_evt = '0; ic_mode = '0;
               exp = (16'((pre | ic)) << (1 + ch)) | (16'((pre & ic)) << (9 + ch));
               rd_chk(exp, "R5 R6 capture flag and overcapture");
            end
         end
      end
      wr(8'h10, 16'h0000);
      cap_evt = 4'h3; ic_mode = 4'h3; tick();
      rd_chk(16'h0006, "R6 first captures no overcapture");
      tick();
      cap_evt = 4'h0; ic_mode = 4'h0;
      rd_chk(16'h0606, "R6 second captures overcapture");

      // R7 break
      wr(8'h10, 16'h0000);
      brk_act = 1'b1; tick();
      rd_chk(16'h0080, "R7 break sets flag");
      wr(8'h10, 16'h0000);
      rd_chk(16'h0080, "R7 clear refused while active");
      brk_act = 1'b0; tick();
      rd_chk(16'h0080, "R7 flag sticky after release");
      wr(8'h10, 16'hFF7F);
      rd_chk(16'h0000, "R7 clear accepted when inactive");

      // R8 trigger edge sweep
      for (int m = 0; m < 8; m++) begin
         wr(8'h10, 16'h0000);
         slave_en = m[0]; gated_mode = m[1]; trig_edge = m[2]; tick();
         trig_edge = 1'b0;
         rd_chk(16'((m[0] & ~m[1] & m[2])) << 6, "R8 trigger edge by mode");
      end
      slave_en = 1'b1; gated_mode = 1'b1;
      wr(8'h10, 16'h0000);
      cnt_run = 1'b1; tick();
      rd_chk(16'h0040, "R8 gated start sets trigger");
      wr(8'h10, 16'h0000);
      tick();
      rd_chk(16'h0000, "R8 gated steady run no trigger");
      cnt_run = 1'b0; tick();
      rd_chk(16'h0040, "R8 gated stop sets trigger");
      slave_en = 1'b0; gated_mode = 1'b0;
      wr(8'h10, 16'h0000);
      cnt_run = 1'b1; tick(); cnt_run = 1'b0; tick();
      rd_chk(16'h0000, "R8 slave disabled no trigger");

      // R4 set wins over clear in the same cycle
      ev_upd = 1'b1; ev_com = 1'b1;
      wr(8'h10, 16'h0000);
      ev_upd = 1'b0; ev_com = 1'b0;
      rd_chk(16'h0021, "R4 set wins over clear");
      ev_cc = 4'h4;
      wr(8'h10, 16'hFFDE);
      ev_cc = 4'h0;
      rd_chk(16'h0008, "R4 channel set with other clears");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule